// File: doc/BRIEF.md
# I2C Register Front-End Bridge

This block sits behind an I2C target physical layer and turns its decoded transaction events (start, stop, written byte, read-byte request) into accesses on a simple local register port. That port addresses a trusted-module style register file and carries a locality tag on every access. The first byte written after a start selects a register by its I2C register number. The bridge maps that number to a backend offset, or serves the register itself when it is kept locally. Every written byte is answered with ACK or NAK.

Writes to the data-FIFO register stream through, one backend write per byte. Writes to other registers are collected, up to four data bytes, and delivered as one little-endian word when the stop arrives. On the first read after a register selection, the bridge captures the register value once. It returns the low byte at once and streams the remaining bytes from the captured copy. Locality select, checksum enable and checksum readout are handled inside the bridge. The status word has its reserved top bits cleared. The interface-capability word is rebuilt for the I2C interface. Device-address change is refused.

The backend port is combinational in both directions. `be_wr` or `be_rd` is raised during the cycle of the event that causes it, and `be_rdata` must be valid in that same cycle. `ack_valid`/`ack_nak` and `rd_valid`/`rd_byte` are registered and appear in the cycle after the event. At most one event is presented per cycle.

Top module: `i2c_reg_bridge`

## Requirements
- R1: The first `ev_wr` byte after a start (or after reset) is taken as the register number and is answered with ACK, including numbers that match no register; later bytes up to the stop are data for that register.
- R2: An address byte of 0x38 (device-address change) is answered with NAK. Data bytes that follow it are also NAKed, and no backend access results.
- R3: Each data byte for register 0x24 (data FIFO) raises `be_wr` in its own event cycle with offset 0x024, size 1 and the byte in `be_wdata[7:0]`. It is ACKed with no byte limit.
- R4: Data bytes for a backend register other than the FIFO are held back. At the stop, one `be_wr` is issued with size equal to the byte count (1 to 4) and the bytes packed little-endian, the first byte in bits 7:0. A stop with no data bytes issues nothing. Offsets: 0x00→0x000, 0x08→0x008, 0x14→0x00C, 0x18→0x018, 0x30→0x014, 0x48→0xF00, 0x4C→0xF04.
- R5: A fifth or later data byte for a non-FIFO register is answered with NAK and dropped; the first four are still delivered at the stop.
- R6: Register 0x04 (locality select) lives in the bridge. A write stores its first data byte at the stop. The stored value drives `be_loc` on every backend access, and a read of 0x04 returns it as a single byte.
- R7: Register 0x20 (checksum enable) lives in the bridge; bit 0 of its first data byte is stored and a read returns it as one byte. Register 0x28 (checksum get) returns `sum_value` as two bytes, low byte first; writes to 0x28 are discarded.
- R8: The first `ev_rd` after a register selection fetches the value once. A backend register raises `be_rd` with size 4 and its bytes are returned low byte first; the FIFO raises `be_rd` with size 1 and yields one byte. Later read requests raise no backend access.
- R9: A read of register 0x18 (status) returns the backend word with bits 31:26 forced to zero.
- R10: A read of register 0x30 (interface capability) returns `(be_rdata & 0x7000_0000) | 0x0000_0082` instead of the backend word.
- R11: Read requests past the captured bytes, and all reads of an unknown register, return 0xFF. Data written to an unknown register is ACKed and discarded without any backend access.
- R12: After reset, `ack_valid`, `rd_valid`, `be_wr` and `be_rd` are low, the stored locality is 0xFF (no locality) and checksum enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start | input | 1 | Start or repeated-start event pulse |
| ev_stop | input | 1 | Stop event pulse |
| ev_wr | input | 1 | Written-byte event pulse |
| ev_wdata | input | 8 | Byte carried by `ev_wr` |
| ev_rd | input | 1 | Read-byte request pulse |
| ack_valid | output | 1 | Response to the previous `ev_wr` is valid |
| ack_nak | output | 1 | 1 = NAK, 0 = ACK (with `ack_valid`) |
| rd_valid | output | 1 | Byte for the previous `ev_rd` is valid |
| rd_byte | output | 8 | Read byte |
| be_wr | output | 1 | Backend write strobe (same cycle as its event) |
| be_rd | output | 1 | Backend read strobe (same cycle as its event) |
| be_addr | output | 12 | Backend register offset |
| be_size | output | 3 | Access size in bytes (1 to 4) |
| be_wdata | output | 32 | Backend write data, little-endian packed |
| be_loc | output | 8 | Stored locality attached to the access |
| be_rdata | input | 32 | Backend read data, valid in the `be_rd` cycle |
| sum_value | input | 16 | Checksum value supplied by the backend |

## Verification
The one cycle where two functions meet is the first read after a selection. In that cycle the backend word is captured into the stream buffer and its low byte, after the status mask or the capability rebuild, is returned directly, bypassing the buffer. The bench provokes this on the status, capability, FIFO, identity and checksum registers. It judges the first byte against the value expected from the live backend model and each later byte against the captured copy, with the backend model answering from the offset presented. It also checks that no second backend read appears.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;
    localparam int BE_AW      = 12;
    localparam int LOC_W      = 8;
    localparam int SUM_W      = 16;
    localparam int CNT_W      = $clog2(WORD_BYTES + 1);

    localparam logic [LOC_W-1:0]  LOC_NONE  = '1;
    localparam logic [BYTE_W-1:0] IDLE_BYTE = '1;
    localparam logic [WORD_W-1:0] STS_KEEP  = 32'h03FF_FFFF;
    localparam logic [WORD_W-1:0] CAP_KEEP  = 32'h7000_0000;
    localparam logic [WORD_W-1:0] CAP_BASE  = 32'h0000_0082;

    typedef enum logic [3:0] {
        RK_NONE, RK_REMOTE, RK_FIFO, RK_STATUS, RK_CAPS,
        RK_LOCALITY, RK_SUM_EN, RK_SUM_GET, RK_DEVADDR
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e        kind;
        logic [BE_AW-1:0] off;
    } reg_info_t;

    // Map an I2C register number onto its handling class and backend offset.
    function automatic reg_info_t decode_reg(input logic [BYTE_W-1:0] code);
        reg_info_t r;
        r.kind = RK_NONE;
        r.off  = '0;
        case (code)
            8'h00: begin r.kind = RK_REMOTE;   r.off = BE_AW'(12'h000); end
            8'h04:       r.kind = RK_LOCALITY;
            8'h08: begin r.kind = RK_REMOTE;   r.off = BE_AW'(12'h008); end
            8'h14: begin r.kind = RK_REMOTE;   r.off = BE_AW'(12'h00C); end
            8'h18: begin r.kind = RK_STATUS;   r.off = BE_AW'(12'h018); end
            8'h20:       r.kind = RK_SUM_EN;
            8'h24: begin r.kind = RK_FIFO;     r.off = BE_AW'(12'h024); end
            8'h28:       r.kind = RK_SUM_GET;
            8'h30: begin r.kind = RK_CAPS;     r.off = BE_AW'(12'h014); end
            8'h38:       r.kind = RK_DEVADDR;
            8'h48: begin r.kind = RK_REMOTE;   r.off = BE_AW'(12'hF00); end
            8'h4C: begin r.kind = RK_REMOTE;   r.off = BE_AW'(12'hF04); end
            default: ;
        endcase
        return r;
    endfunction

    function automatic logic goes_to_backend(input reg_kind_e k);
        return (k == RK_REMOTE) || (k == RK_FIFO) || (k == RK_STATUS) || (k == RK_CAPS);
    endfunction

endpackage

// File: rtl/i2cb_wcollect.sv
module i2cb_wcollect
    import i2cb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_wr,
    input  logic [BYTE_W-1:0] ev_wdata,
    output logic [BYTE_W-1:0] reg_q,
    output logic              reg_new,
    output logic              fifo_push,
    output logic              flush,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [WORD_W-1:0] word_q,
    output logic              ack_valid,
    output logic              ack_nak
);
    logic      need_addr;
    logic      data_byte;
    logic      addr_is_dev;
    reg_kind_e cur_kind;

    assign cur_kind    = decode_reg(reg_q).kind;
    assign addr_is_dev = (decode_reg(ev_wdata).kind == RK_DEVADDR);
    assign data_byte   = ev_wr && !need_addr;
    assign reg_new     = ev_wr && need_addr;
    assign fifo_push   = data_byte && (cur_kind == RK_FIFO);
    assign flush       = ev_stop && (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            need_addr <= 1'b1;
            reg_q     <= IDLE_BYTE;
            cnt_q     <= '0;
            word_q    <= '0;
            ack_valid <= 1'b0;
            ack_nak   <= 1'b0;
        end else begin
            ack_valid <= ev_wr;
            ack_nak   <= 1'b0;
            if (ev_start || ev_stop) begin
                need_addr <= 1'b1;
                cnt_q     <= '0;
            end else if (reg_new) begin
                reg_q     <= ev_wdata;
                need_addr <= 1'b0;
                cnt_q     <= '0;
                word_q    <= '0;
                ack_nak   <= addr_is_dev;
            end else if (data_byte) begin
                if (cur_kind == RK_DEVADDR) begin
                    ack_nak <= 1'b1;
                end else if (cur_kind != RK_FIFO) begin
                    if (cnt_q < CNT_W'(WORD_BYTES)) begin
                        word_q[int'(cnt_q[1:0])*BYTE_W +: BYTE_W] <= ev_wdata;
                        cnt_q <= cnt_q + CNT_W'(1);
                    end else begin
                        ack_nak <= 1'b1;
                    end
                end
            end
        end
    end

    assert_devaddr_nak_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_new && addr_is_dev) |=> (ack_valid && ack_nak));

    assert_full_nak_R5: assert property (@(posedge clk) disable iff (rst)
        (data_byte && cur_kind == RK_REMOTE && cnt_q == CNT_W'(WORD_BYTES))
        |=> (ack_nak && cnt_q == CNT_W'(WORD_BYTES)));

endmodule

// File: rtl/i2cb_rstream.sv
module i2cb_rstream
    import i2cb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_rd,
    input  logic              reg_new,
    input  logic [WORD_W-1:0] fetch_word,
    input  logic [CNT_W-1:0]  fetch_len,
    output logic              need_fetch,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_byte
);
    logic              fetched;
    logic [WORD_W-1:0] cap_q;
    logic [CNT_W-1:0]  len_q;
    logic [CNT_W-1:0]  idx_q;

    assign need_fetch = ev_rd && !fetched;

    always_ff @(posedge clk) begin
        if (rst) begin
            fetched  <= 1'b0;
            cap_q    <= '0;
            len_q    <= '0;
            idx_q    <= '0;
            rd_valid <= 1'b0;
            rd_byte  <= IDLE_BYTE;
        end else begin
            rd_valid <= ev_rd;
            if (reg_new) begin
                fetched <= 1'b0;
            end else if (need_fetch) begin
                cap_q   <= fetch_word;
                len_q   <= fetch_len;
                idx_q   <= CNT_W'(1);
                fetched <= 1'b1;
                rd_byte <= (fetch_len != '0) ? fetch_word[BYTE_W-1:0] : IDLE_BYTE;
            end else if (ev_rd) begin
                if (idx_q < len_q) begin
                    rd_byte <= cap_q[int'(idx_q[1:0])*BYTE_W +: BYTE_W];
                    idx_q   <= idx_q + CNT_W'(1);
                end else begin
                    rd_byte <= IDLE_BYTE;
                end
            end
        end
    end

    assert_past_end_R11: assert property (@(posedge clk) disable iff (rst)
        (ev_rd && fetched && idx_q >= len_q) |=> (rd_valid && rd_byte == IDLE_BYTE));

endmodule

// File: rtl/i2c_reg_bridge.sv
module i2c_reg_bridge
    import i2cb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_wr,
    input  logic [BYTE_W-1:0] ev_wdata,
    input  logic              ev_rd,
    output logic              ack_valid,
    output logic              ack_nak,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              be_wr,
    output logic              be_rd,
    output logic [BE_AW-1:0]  be_addr,
    output logic [CNT_W-1:0]  be_size,
    output logic [WORD_W-1:0] be_wdata,
    output logic [LOC_W-1:0]  be_loc,
    input  logic [WORD_W-1:0] be_rdata,
    input  logic [SUM_W-1:0]  sum_value
);
    logic [BYTE_W-1:0] reg_q;
    logic              reg_new, fifo_push, flush, need_fetch;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] fetch_word;
    logic [CNT_W-1:0]  fetch_len;
    logic [LOC_W-1:0]  loc_q;
    logic              sum_en_q;
    reg_info_t         info;

    assign info = decode_reg(reg_q);

    i2cb_wcollect u_wcol (
        .clk(clk), .rst(rst), .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_wr(ev_wr), .ev_wdata(ev_wdata), .reg_q(reg_q), .reg_new(reg_new),
        .fifo_push(fifo_push), .flush(flush), .cnt_q(cnt_q), .word_q(word_q),
        .ack_valid(ack_valid), .ack_nak(ack_nak)
    );

    i2cb_rstream u_rstr (
        .clk(clk), .rst(rst), .ev_rd(ev_rd), .reg_new(reg_new),
        .fetch_word(fetch_word), .fetch_len(fetch_len), .need_fetch(need_fetch),
        .rd_valid(rd_valid), .rd_byte(rd_byte)
    );

    // Backend port: driven in the cycle of the causing event.
    assign be_wr = fifo_push ||
                   (flush && goes_to_backend(info.kind) && info.kind != RK_FIFO);
    assign be_rd    = need_fetch && goes_to_backend(info.kind);
    assign be_addr  = info.off;
    assign be_loc   = loc_q;
    assign be_wdata = fifo_push ? WORD_W'(ev_wdata) : word_q;

    always_comb begin
        if (fifo_push)      be_size = CNT_W'(1);
        else if (be_rd)     be_size = (info.kind == RK_FIFO) ? CNT_W'(1) : CNT_W'(WORD_BYTES);
        else                be_size = cnt_q;
    end

    // Value captured on the first read of a selected register.
    always_comb begin
        fetch_word = '0;
        fetch_len  = '0;
        case (info.kind)
            RK_FIFO:     begin fetch_word = WORD_W'(be_rdata[BYTE_W-1:0]);  fetch_len = CNT_W'(1); end
            RK_REMOTE:   begin fetch_word = be_rdata;                       fetch_len = CNT_W'(WORD_BYTES); end
            RK_STATUS:   begin fetch_word = be_rdata & STS_KEEP;            fetch_len = CNT_W'(WORD_BYTES); end
            RK_CAPS:     begin fetch_word = (be_rdata & CAP_KEEP) | CAP_BASE; fetch_len = CNT_W'(WORD_BYTES); end
            RK_LOCALITY: begin fetch_word = WORD_W'(loc_q);                 fetch_len = CNT_W'(1); end
            RK_SUM_EN:   begin fetch_word = WORD_W'(sum_en_q);              fetch_len = CNT_W'(1); end
            RK_SUM_GET:  begin fetch_word = WORD_W'(sum_value);             fetch_len = CNT_W'(2); end
            default: ;
        endcase
    end

    // Registers kept inside the bridge.
    always_ff @(posedge clk) begin
        if (rst) begin
            loc_q    <= LOC_NONE;
            sum_en_q <= 1'b0;
        end else if (flush) begin
            if (info.kind == RK_LOCALITY) loc_q    <= word_q[LOC_W-1:0];
            if (info.kind == RK_SUM_EN)   sum_en_q <= word_q[0];
        end
    end

    assert_loc_store_R6: assert property (@(posedge clk) disable iff (rst)
        (flush && info.kind == RK_LOCALITY) |=> (be_loc == $past(word_q[LOC_W-1:0])));

    assert_sum_en_store_R7: assert property (@(posedge clk) disable iff (rst)
        (flush && info.kind == RK_SUM_EN) |=> (sum_en_q == $past(word_q[0])));

    assert_fetch_once_R8: assert property (@(posedge clk) disable iff (rst)
        (ev_rd && !need_fetch) |-> !be_rd);

endmodule

// File: tb/i2c_reg_bridge_test.sv
module i2c_reg_bridge_test;
    import i2cb_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1;
    logic ev_start = 0, ev_stop = 0, ev_wr = 0, ev_rd = 0;
    logic [7:0] ev_wdata = 8'h00;
    logic ack_valid, ack_nak, rd_valid;
    logic [7:0] rd_byte;
    logic be_wr, be_rd;
    logic [11:0] be_addr;
    logic [2:0] be_size;
    logic [31:0] be_wdata, be_rdata;
    logic [7:0] be_loc;
    logic [15:0] sum_value;

    assign be_rdata  = {8'hFE, 8'hD0, 4'h0, be_addr};
    assign sum_value = 16'hBEEF;

    i2c_reg_bridge uut (
        .clk(clk), .rst(rst), .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_wr(ev_wr), .ev_wdata(ev_wdata), .ev_rd(ev_rd),
        .ack_valid(ack_valid), .ack_nak(ack_nak), .rd_valid(rd_valid), .rd_byte(rd_byte),
        .be_wr(be_wr), .be_rd(be_rd), .be_addr(be_addr), .be_size(be_size),
        .be_wdata(be_wdata), .be_loc(be_loc), .be_rdata(be_rdata), .sum_value(sum_value)
    );

    typedef struct packed {
        logic        we;
        logic [11:0] addr;
        logic [2:0]  size;
        logic [31:0] data;
        logic [7:0]  loc;
    } acc_t;

    int   checks = 0;
    int   fails  = 0;
    logic  ack_q[$];
    string ack_tag[$];
    logic [7:0] rd_q[$];
    string rd_tag[$];
    acc_t  acc_q[$];
    string acc_tag[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor: compares results as the design produces them.
    always @(negedge clk) begin
        if (!rst) begin
            if (ack_valid) begin
                if (ack_q.size() == 0) check(0, "R1", "unexpected ack", 64'(ack_nak), 0);
                else begin
                    automatic logic e = ack_q.pop_front();
                    automatic string t = ack_tag.pop_front();
                    check(ack_nak == e, t, "ack/nak", 64'(ack_nak), 64'(e));
                end
            end
            if (rd_valid) begin
                if (rd_q.size() == 0) check(0, "R8", "unexpected read byte", 64'(rd_byte), 0);
                else begin
                    automatic logic [7:0] e = rd_q.pop_front();
                    automatic string t = rd_tag.pop_front();
                    check(rd_byte == e, t, "read byte", 64'(rd_byte), 64'(e));
                end
            end
            if (be_wr || be_rd) begin
                if (acc_q.size() == 0)
                    check(0, "R11", "unexpected backend access", 64'({be_wr, be_addr}), 0);
                else begin
                    automatic acc_t e = acc_q.pop_front();
                    automatic string t = acc_tag.pop_front();
                    automatic acc_t a;
                    a.we = be_wr; a.addr = be_addr; a.size = be_size;
                    a.data = be_wr ? be_wdata : 32'h0; a.loc = be_loc;
                    check(a == e && !(be_wr && be_rd), t, "backend access", 64'(a), 64'(e));
                end
            end
        end
    end

    task automatic pulse_start();
        @(posedge clk); #1 ev_start = 1;
        @(posedge clk); #1 ev_start = 0;
    endtask

    task automatic pulse_stop();
        @(posedge clk); #1 ev_stop = 1;
        @(posedge clk); #1 ev_stop = 0;
    endtask

    task automatic wr(input logic [7:0] b, input logic nak, input string tag);
        ack_q.push_back(nak); ack_tag.push_back(tag);
        @(posedge clk); #1 ev_wr = 1; ev_wdata = b;
        @(posedge clk); #1 ev_wr = 0;
    endtask

    task automatic rd(input logic [7:0] exp, input string tag);
        rd_q.push_back(exp); rd_tag.push_back(tag);
        @(posedge clk); #1 ev_rd = 1;
        @(posedge clk); #1 ev_rd = 0;
    endtask

    task automatic expect_acc(input logic we, input logic [11:0] addr, input logic [2:0] size,
                              input logic [31:0] data, input logic [7:0] loc, input string tag);
        acc_t e;
        e.we = we; e.addr = addr; e.size = size; e.data = we ? data : 32'h0; e.loc = loc;
        acc_q.push_back(e); acc_tag.push_back(tag);
    endtask

    task automatic select_and_read(input logic [7:0] r);
        pulse_start();
        wr(r, 1'b0, "R1");
        pulse_start();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        check(!ack_valid && !rd_valid && !be_wr && !be_rd, "R12", "reset outputs",
              64'({ack_valid, rd_valid, be_wr, be_rd}), 0);
        check(be_loc == 8'hFF, "R12", "reset locality", 64'(be_loc), 64'hFF);

        // R12: locality reads back as no-locality, checksum enable as 0
        select_and_read(8'h04); rd(8'hFF, "R12"); pulse_stop();
        select_and_read(8'h20); rd(8'h00, "R12"); pulse_stop();

        // R6: set locality 2, read it back, then past end (R11)
        pulse_start(); wr(8'h04, 0, "R1"); wr(8'h02, 0, "R6"); pulse_stop();
        select_and_read(8'h04); rd(8'h02, "R6"); rd(8'hFF, "R11"); pulse_stop();

        // R4: single-byte buffered write delivered at stop
        pulse_start(); wr(8'h00, 0, "R1"); wr(8'h20, 0, "R4");
        expect_acc(1, 12'h000, 3'd1, 32'h0000_0020, 8'h02, "R4");
        pulse_stop();

        // R4/R5: four bytes packed little-endian, fifth NAKed
        pulse_start(); wr(8'h08, 0, "R1");
        wr(8'h11, 0, "R4"); wr(8'h22, 0, "R4"); wr(8'h33, 0, "R4"); wr(8'h44, 0, "R4");
        wr(8'h55, 1, "R5");
        expect_acc(1, 12'h008, 3'd4, 32'h4433_2211, 8'h02, "R5");
        pulse_stop();

        // R4: two bytes to a remapped register
        pulse_start(); wr(8'h14, 0, "R1"); wr(8'hA1, 0, "R4"); wr(8'hB2, 0, "R4");
        expect_acc(1, 12'h00C, 3'd2, 32'h0000_B2A1, 8'h02, "R4");
        pulse_stop();

        // R4: zero data bytes, no access
        pulse_start(); wr(8'h08, 0, "R1"); pulse_stop();

        // R3: FIFO streams each byte, no limit
        pulse_start(); wr(8'h24, 0, "R1");
        for (int i = 0; i < 6; i++) begin
            expect_acc(1, 12'h024, 3'd1, 32'(8'hA0 + i), 8'h02, "R3");
            wr(8'(8'hA0 + i), 0, "R3");
        end
        pulse_stop();

        // R2: device-address register refused
        pulse_start(); wr(8'h38, 1, "R2"); wr(8'h01, 1, "R2"); pulse_stop();

        // R11: unknown register ACKed, data discarded, reads 0xFF
        pulse_start(); wr(8'h7C, 0, "R11"); wr(8'h09, 0, "R11"); pulse_stop();
        select_and_read(8'h7C); rd(8'hFF, "R11"); rd(8'hFF, "R11"); pulse_stop();

        // R9: status with reserved bits cleared
        select_and_read(8'h18);
        expect_acc(0, 12'h018, 3'd4, 0, 8'h02, "R9");
        rd(8'h18, "R9"); rd(8'h00, "R9"); rd(8'hD0, "R9"); rd(8'h02, "R9");
        rd(8'hFF, "R11"); pulse_stop();

        // R10: capability word rebuilt
        select_and_read(8'h30);
        expect_acc(0, 12'h014, 3'd4, 0, 8'h02, "R10");
        rd(8'h82, "R10"); rd(8'h00, "R10"); rd(8'h00, "R10"); rd(8'h70, "R10");
        pulse_stop();

        // R8: FIFO read fetches one byte once
        select_and_read(8'h24);
        expect_acc(0, 12'h024, 3'd1, 0, 8'h02, "R8");
        rd(8'h24, "R8"); rd(8'hFF, "R8"); pulse_stop();

        // R8: identity register, 4 bytes little-endian
        select_and_read(8'h48);
        expect_acc(0, 12'hF00, 3'd4, 0, 8'h02, "R8");
        rd(8'h00, "R8"); rd(8'h0F, "R8"); rd(8'hD0, "R8"); rd(8'hFE, "R8");
        pulse_stop();

        // R7: checksum enable and checksum readout
        pulse_start(); wr(8'h20, 0, "R1"); wr(8'h01, 0, "R7"); pulse_stop();
        select_and_read(8'h20); rd(8'h01, "R7"); pulse_stop();
        pulse_start(); wr(8'h28, 0, "R1"); wr(8'h55, 0, "R7"); pulse_stop();
        select_and_read(8'h28); rd(8'hEF, "R7"); rd(8'hBE, "R7"); rd(8'hFF, "R11"); pulse_stop();

        repeat (4) @(posedge clk);
        @(negedge clk);
        check(ack_q.size() == 0, "R1", "pending acks", 64'(ack_q.size()), 0);
        check(rd_q.size() == 0, "R8", "pending read bytes", 64'(rd_q.size()), 0);
        check(acc_q.size() == 0, "R4", "pending backend accesses", 64'(acc_q.size()), 0);
        finish_run();
    end

endmodule